// File: doc/BRIEF.md
# Clamped Delta Sample Compressor

This block losslessly compresses a stream of digitised detector samples. One frame holds one 16-bit word from each of 16 channels. The upper six bits of every input word carry hit-detector flags, and the block throws them away. It keeps the 10-bit converter value and compares it with the value that the same channel delivered in the previous frame. Small changes become a 4-bit offset code. Four codes are packed into one 16-bit output word. A change too large for a code is marked with the reserved code zero, and the full value is sent as an extra word right after the packed word of that group.

The input side takes one word per handshake, plus a flag that marks channel 0 of a frame. The output side is a valid/ready stream of encoded words. The controller is a three-state machine:

- `ST_COLLECT` accepts samples and has `in_ready` high.
- On the fourth sample of a group it takes the transition *group full* to `ST_EMIT_PACK`, which offers the packed word.
- If the packed word is accepted and the group holds no escapes, the *pack done, clean* transition returns it to `ST_COLLECT`.
- If the packed word is accepted and the group has escapes, the *pack done, escapes pending* transition moves it to `ST_EMIT_ESC`. This state offers the full values in rising channel order.
- The *last escape taken* transition returns it to `ST_COLLECT`.

Top module: `cdelta_compressor`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, the channel counter is 0, and every channel's stored previous value is 0.
- R2: Only `in_data[9:0]` is coded and stored. Bits 15:10 of an input word have no effect on any output word.
- R3: The difference d is the current value minus the same channel's previous value. When -8 < d < 8 the channel's code is d + 8, which lies in the range 1 to 15.
- R4: When d <= -8 or d >= 8 the channel's code is 0, and that channel is escaped.
- R5: Channels 4k to 4k+3 form one group. Their codes make up one packed word, with channel 4k in bits 15:12, then 11:8, then 7:4, and channel 4k+3 in bits 3:0.
- R6: Right after a group's packed word, one word `{6'b0, value}` is sent for each escaped channel of that group, in rising channel order. No other word comes between them.
- R7: Every accepted sample becomes its channel's previous value, whether it was escaped or not.
- R8: `in_ready` goes low in the cycle after the fourth sample of a group is accepted. It stays low until the last output word of that group is accepted.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R10: A word with `in_sof` = 1 is channel 0, and any unfinished group is dropped without output. A word with `in_sof` = 0 is the channel after the last accepted one, and channel 15 wraps to channel 0.
- R11: In the first frame after reset every difference is taken from a previous value of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block accepts an input word |
| in_sof | input | 1 | Offered word is channel 0 of a frame |
| in_data | input | 16 | Sample: flags in 15:10, value in 9:0 |
| out_valid | output | 1 | Encoded word offered |
| out_ready | input | 1 | Consumer accepts the encoded word |
| out_data | output | 16 | Packed code word or escaped full value |

## Verification
The hardest case to reach is a restart in the middle of a group. A frame-start word must then drop a half-built group without emitting it, while the history of the dropped channels is still updated. The stimulus sends two samples and then a new frame with the start flag set. The dropped samples repeat the stored values, so a decoder that never saw them stays in step. Any misalignment of the channel counter then shows up as wrong codes in the next packed words.

The other corners come from sweeping the per-channel delta over -10 to +10 across many frames, so that each group sees both sides of the ±8 limit. Full-range jumps and a consumer that stalls irregularly are also applied.

// File: rtl/cdc_pkg.sv
package cdc_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT   = 2'd0,
        ST_EMIT_PACK = 2'd1,
        ST_EMIT_ESC  = 2'd2
    } cdc_state_e;

endpackage

// File: rtl/cdc_history.sv
module cdc_history #(
    parameter int NUM_CH = 16,
    parameter int VAL_W  = 10,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [VAL_W-1:0] rd_val,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [VAL_W-1:0] wr_val
);

    logic [VAL_W-1:0] hist_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hist_q[g] <= '0;
            end else if (wr_en && (wr_ch == CH_W'(g))) begin
                hist_q[g] <= wr_val;
            end
        end
    end

    assign rd_val = hist_q[rd_ch];

endmodule

// File: rtl/cdc_delta_code.sv
module cdc_delta_code #(
    parameter int VAL_W  = 10,
    parameter int CODE_W = 4
) (
    input  logic [VAL_W-1:0]  cur_val,
    input  logic [VAL_W-1:0]  prev_val,
    output logic [CODE_W-1:0] code,
    output logic              escape
);

    localparam int LIM = 2 ** (CODE_W - 1);
    localparam logic signed [VAL_W:0] LIM_S = (VAL_W + 1)'(LIM);

    logic signed [VAL_W:0] diff;
    logic signed [VAL_W:0] shifted;
    logic                  fits;

    always_comb begin
        diff    = $signed({1'b0, cur_val}) - $signed({1'b0, prev_val});
        shifted = diff + LIM_S;
        fits    = (diff > -LIM_S) && (diff < LIM_S);
        escape  = !fits;
        code    = fits ? shifted[CODE_W-1:0] : '0;
    end

endmodule

// File: rtl/cdc_group_ctrl.sv
module cdc_group_ctrl
    import cdc_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int VAL_W   = 10,
    parameter int CODE_W  = 4,
    parameter int WORD_W  = 16,
    localparam int LANES  = WORD_W / CODE_W,
    localparam int LANE_W = $clog2(LANES),
    localparam int CH_W   = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    output logic              in_ready,
    input  logic [VAL_W-1:0]  smp_val,
    input  logic [CODE_W-1:0] smp_code,
    input  logic              smp_esc,
    output logic [CH_W-1:0]   cur_ch,
    output logic              take,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);

    cdc_state_e state_q, state_d;

    logic [CH_W-1:0]   ch_q;
    logic [LANE_W-1:0] lane;
    logic [CODE_W-1:0] nib_q [LANES];
    logic [VAL_W-1:0]  val_q [LANES];
    logic [LANES-1:0]  esc_q;
    logic [LANES-1:0]  esc_rest;
    logic [LANE_W-1:0] sel;
    logic              sel_found;
    logic              last_lane;

    assign cur_ch    = in_sof ? '0 : ch_q;
    assign lane      = cur_ch[LANE_W-1:0];
    assign last_lane = (lane == LANE_W'(LANES - 1));
    assign take      = in_valid && in_ready;

    // lowest pending escape lane
    always_comb begin
        sel       = '0;
        sel_found = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (esc_q[i] && !sel_found) begin
                sel       = LANE_W'(i);
                sel_found = 1'b1;
            end
        end
        esc_rest = esc_q & ~(LANES'(1) << sel);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: begin
                if (take && last_lane) state_d = ST_EMIT_PACK;
            end
            ST_EMIT_PACK: begin
                if (out_ready) state_d = (esc_q != '0) ? ST_EMIT_ESC : ST_COLLECT;
            end
            ST_EMIT_ESC: begin
                if (out_ready && (esc_rest == '0)) state_d = ST_COLLECT;
            end
            default: state_d = ST_COLLECT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // group data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q  <= '0;
            esc_q <= '0;
            for (int i = 0; i < LANES; i++) begin
                nib_q[i] <= '0;
                val_q[i] <= '0;
            end
        end else begin
            if (take) begin
                nib_q[lane] <= smp_code;
                val_q[lane] <= smp_val;
                if (lane == '0) esc_q <= LANES'(smp_esc);
                else            esc_q <= esc_q | (LANES'(smp_esc) << lane);
                ch_q <= (cur_ch == CH_W'(NUM_CH - 1)) ? '0 : cur_ch + CH_W'(1);
            end else if ((state_q == ST_EMIT_ESC) && out_ready) begin
                esc_q <= esc_rest;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        unique case (state_q)
            ST_COLLECT: begin
                in_ready = 1'b1;
            end
            ST_EMIT_PACK: begin
                out_valid = 1'b1;
                for (int i = 0; i < LANES; i++) begin
                    out_data[WORD_W-1-i*CODE_W -: CODE_W] = nib_q[i];
                end
            end
            ST_EMIT_ESC: begin
                out_valid = 1'b1;
                out_data  = WORD_W'(val_q[sel]);
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
    end

    // assertion helper: a packed word on the port carries an escape nibble
    logic port_has_zero_nib;
    always_comb begin
        port_has_zero_nib = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (out_data[WORD_W-1-i*CODE_W -: CODE_W] == '0) port_has_zero_nib = 1'b1;
        end
    end

    AST_PACK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last_lane) |=> (out_valid && !in_ready)); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

    AST_ESC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EMIT_PACK) && out_ready && port_has_zero_nib) |=> (state_q == ST_EMIT_ESC)); // R6

    AST_ESC_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EMIT_ESC) && out_ready) |=> ($countones(esc_q) + 1 == $countones($past(esc_q)))); // R6

endmodule

// File: rtl/cdelta_compressor.sv
module cdelta_compressor #(
    parameter int NUM_CH = 16,
    parameter int VAL_W  = 10,
    parameter int CODE_W = 4,
    parameter int WORD_W = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);

    logic [VAL_W-1:0]  smp_val;
    logic [VAL_W-1:0]  prev_val;
    logic [CODE_W-1:0] smp_code;
    logic              smp_esc;
    logic [CH_W-1:0]   cur_ch;
    logic              take;

    assign smp_val = in_data[VAL_W-1:0];

    cdc_history #(
        .NUM_CH (NUM_CH),
        .VAL_W  (VAL_W)
    ) u_hist (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_ch  (cur_ch),
        .rd_val (prev_val),
        .wr_en  (take),
        .wr_ch  (cur_ch),
        .wr_val (smp_val)
    );

    cdc_delta_code #(
        .VAL_W  (VAL_W),
        .CODE_W (CODE_W)
    ) u_code (
        .cur_val  (smp_val),
        .prev_val (prev_val),
        .code     (smp_code),
        .escape   (smp_esc)
    );

    cdc_group_ctrl #(
        .NUM_CH (NUM_CH),
        .VAL_W  (VAL_W),
        .CODE_W (CODE_W),
        .WORD_W (WORD_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_ready  (in_ready),
        .smp_val   (smp_val),
        .smp_code  (smp_code),
        .smp_esc   (smp_esc),
        .cur_ch    (cur_ch),
        .take      (take),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

endmodule

// File: tb/cdelta_compressor_bench.sv
module cdelta_compressor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sof = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;

    always #4 clk = ~clk;

    cdelta_compressor u_cdelta_compressor (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_sof    (in_sof),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit mon_on = 0;
    string phase_tag = "R5";

    // expected stream (bench model built from the requirements)
    logic [15:0] q_word [$];
    bit          q_esc  [$];
    int          q_ch   [$];
    logic [39:0] q_vals [$];
    logic [3:0]  q_escm [$];

    int          m_prev [16];
    int          m_ch = 0;
    logic [3:0]  m_code [4];
    int          m_val  [4];
    logic [3:0]  m_escf;
    int          dec_prev [16];
    bit          first_pack = 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_take(input logic [15:0] d, input bit sof, output bit grp_end);
        int ch, ln, v, df;
        ch = sof ? 0 : m_ch;
        ln = ch % 4;
        v  = int'(d[9:0]);
        df = v - m_prev[ch];
        m_prev[ch] = v;
        if (ln == 0) m_escf = 4'b0;
        m_val[ln] = v;
        if (df > -8 && df < 8) m_code[ln] = 4'(df + 8);
        else begin m_code[ln] = 4'h0; m_escf[ln] = 1'b1; end
        grp_end = (ln == 3);
        if (grp_end) begin
            q_word.push_back({m_code[0], m_code[1], m_code[2], m_code[3]});
            q_esc.push_back(1'b0);
            q_ch.push_back(ch - 3);
            q_vals.push_back({10'(m_val[0]), 10'(m_val[1]), 10'(m_val[2]), 10'(m_val[3])});
            q_escm.push_back(m_escf);
            for (int i = 0; i < 4; i++) begin
                if (m_escf[i]) begin
                    q_word.push_back(16'(m_val[i]));
                    q_esc.push_back(1'b1);
                    q_ch.push_back(ch - 3 + i);
                    q_vals.push_back(40'(m_val[i]));
                    q_escm.push_back(4'b0);
                end
            end
        end
        m_ch = (ch + 1) % 16;
    endtask

    // call at a negedge
    task automatic send(input logic [15:0] d, input bit sof);
        bit ge;
        in_valid = 1'b1;
        in_data  = d;
        in_sof   = sof;
        while (!in_ready) @(negedge clk);
        model_take(d, sof, ge);
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        if (ge) chk(!in_ready && out_valid, "R8 stall after group", {in_ready, out_valid}, 2'b01);
    endtask

    // output monitor and decoder
    bit          prev_stall = 0;
    logic [15:0] prev_word = '0;
    int          cyc = 0;
    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (prev_stall)
                chk(out_valid && out_data == prev_word, "R9 hold while stalled", out_data, prev_word);
            out_ready = ((cyc % 7) != 2) && ((cyc % 11) != 5);
            if (out_valid && out_ready) begin
                if (q_word.size() == 0) begin
                    chk(0, "R6 unexpected word", out_data, 0);
                end else begin
                    logic [15:0] ew; bit ee; int ec; logic [39:0] ev; logic [3:0] em;
                    ew = q_word.pop_front(); ee = q_esc.pop_front(); ec = q_ch.pop_front();
                    ev = q_vals.pop_front(); em = q_escm.pop_front();
                    if (!ee) begin
                        chk(out_data == ew, phase_tag, out_data, ew);
                        if (first_pack) begin
                            // R11: first group after reset from zero history (3,7,20,0)
                            chk(out_data == 16'hBF08, "R11 first frame codes", out_data, 16'hBF08);
                            first_pack = 0;
                        end
                        for (int i = 0; i < 4; i++) begin
                            logic [3:0] nb;
                            int want;
                            nb = out_data[15-4*i -: 4];
                            want = int'(ev[39-10*i -: 10]);
                            chk((nb == 4'h0) == em[i], "R4 escape code", nb, em[i]);
                            if (nb != 4'h0) begin
                                dec_prev[ec+i] = dec_prev[ec+i] + int'(nb) - 8;
                                chk(dec_prev[ec+i] == want, "R3/R7 decoded delta", dec_prev[ec+i], want);
                            end
                        end
                    end else begin
                        chk(out_data == ew, "R6 escape word", out_data, ew);
                        dec_prev[ec] = int'(out_data[9:0]);
                        chk(out_data[15:10] == 6'b0 && dec_prev[ec] == int'(ev[9:0]),
                            "R2 flags dropped", out_data, ev[15:0]);
                    end
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_word  = out_data;
        end
    end

    // watchdog
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [15:0] mk(input int v, input int flags);
        return {6'(flags), 10'(v)};
    endfunction

    int lcg = 32'h1234;

    initial begin
        for (int i = 0; i < 16; i++) begin m_prev[i] = 0; dec_prev[i] = 0; end
        m_escf = 4'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R1 reset state", {in_ready, out_valid}, 2'b10);
        mon_on = 1;

        // R11: first frame, history is all zero
        send(mk(3, 6'h3f), 1);
        send(mk(7, 6'h15), 0);
        send(mk(20, 6'h2a), 0);
        send(mk(0, 6'h01), 0);
        for (int c = 4; c < 16; c++) send(mk(c * 37 % 1024, c), 0);

        // delta sweep -10..+10 across channels and frames (R3, R4, R2 flags vary)
        for (int f = 0; f < 24; f++) begin
            for (int c = 0; c < 16; c++) begin
                int dl, nv;
                dl = ((f * 5 + c * 3) % 21) - 10;
                nv = m_prev[c] + dl;
                if (nv < 0 || nv > 1023) nv = m_prev[c] - dl;
                send(mk(nv, (f * 7 + c) & 63), c == 0);
            end
        end

        // full-range jumps and pseudo-random values
        for (int f = 0; f < 10; f++) begin
            for (int c = 0; c < 16; c++) begin
                int nv;
                lcg = lcg * 1103515245 + 12345;
                nv = (f % 3 == 0) ? ((c % 2 == 0) ? 1023 : 0) : ((lcg >>> 8) & 1023);
                send(mk(nv, (lcg >>> 20) & 63), c == 0);
            end
        end

        // R10: frame without a start flag continues after channel 15 wrap
        phase_tag = "R10 wrap";
        for (int c = 0; c < 16; c++) send(mk((m_prev[c] + (c % 5) - 2 + 1024) % 1024, 6'h3f), 0);

        // R10: restart mid-group; dropped samples repeat stored values
        send(mk(m_prev[0], 0), 1);
        send(mk(m_prev[1], 0), 0);
        for (int c = 0; c < 16; c++) send(mk((m_prev[c] + 3) % 1024, 6'h10), c == 0);
        for (int c = 0; c < 16; c++) send(mk((m_prev[c] + 1021) % 1024, 6'h20), c == 0);
        phase_tag = "R5";
        for (int c = 0; c < 16; c++) send(mk((m_prev[c] + 9) % 1024, 0), c == 0);

        while (q_word.size() != 0 || out_valid) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(q_word.size() == 0 && !out_valid, "R6 stream drained", q_word.size(), 0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule